// File: doc/BRIEF.md
# Rotating-Track Sector Transfer Sequencer

This block is the control sequencer for moving one sector to or from a rotating track store. It keeps a one-hot, four-state status register: idle, armed (`TRA`), active (`ACT`) and finished (`FLAG`). A host command opens a transfer and picks its direction. A second host command loads the track and sector address and starts a settle timer; when that timer runs out the sequencer arms. From the armed state, the medium's index pulse opens the active window. The window closes when the medium clock has been absent for a gap timeout.

When the active window closes, the sequencer raises its finished flag and steps the combined track/sector address by one. A continue command re-arms the sequencer straight from the finished state for a back-to-back sector. Sense commands return a one-cycle skip answer based on the finished flag or on the two error flags. The serial data path, parity generation and host memory access sit outside the block. The data path reports errors on two set inputs.

The index and medium clock inputs are asynchronous. Each passes through a synchroniser and a rising-edge detector. Every delay is a cycle count derived from the system clock frequency.

Top module: `rotstore_seq`

## Requirements
- R1: After reset the state is idle (`seq_state` = 4'b0001, where bit 0 is idle, bit 1 armed, bit 2 active and bit 3 finished). `xfer_active`, `flag_out` and `dir_write` are 0, the address is 0 and both error flags are clear.
- R2: `cmd_start_write` or `cmd_start_read` forces idle from any state, clears both error flags and sets `dir_write` to 1 for write or 0 for read. Write wins if both are given.
- R3: `cmd_load_addr` in idle loads the track from `addr_in[ADDR_W-1:SEC_W]` and the sector from `addr_in[SEC_W-1:0]`, and starts the settle timer. The armed state is entered SETTLE_CYC+1 cycles after the command edge. The command is ignored outside idle.
- R4: In the armed state, a rising index edge enters the active state; the index is ignored in idle.
- R5: The active state holds while medium clock edges arrive less than GAP_CYC cycles apart. It moves to finished once no edge has been seen for GAP_CYC cycles.
- R6: On leaving the active state, `addr_adv` pulses for one cycle and the address increments by one. A carry out of the last sector (all ones) steps the track and wraps the sector to 0.
- R7: `cmd_continue` in the finished state enters the armed state, pulses `take_word` for one cycle and clears both error flags. It is ignored in any other state.
- R8: `cmd_sense_flag` makes `skip` 1 in the next cycle exactly when the finished state is held.
- R9: `par_err_set` and `data_err_set` set their error flags. `cmd_sense_err` makes `skip` 1 in the next cycle only when both flags are clear. An error set in the same cycle as a clear by continue leaves the flag set.
- R10: Exactly one state bit is set at all times. Idle is entered only by reset or a start command. The armed state is entered only from idle or finished, active only from armed, and finished only from active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start_write | input | 1 | Open a write transfer (one-cycle pulse) |
| cmd_start_read | input | 1 | Open a read transfer (one-cycle pulse) |
| cmd_load_addr | input | 1 | Load track/sector address and start settle timer |
| addr_in | input | ADDR_W | Track in the high bits, sector in the low SEC_W bits |
| cmd_continue | input | 1 | Re-arm for the next sector from finished |
| cmd_sense_flag | input | 1 | Ask whether finished is set |
| cmd_sense_err | input | 1 | Ask whether both error flags are clear |
| par_err_set | input | 1 | Parity error report from the data path |
| data_err_set | input | 1 | Data error report from the data path |
| index_raw | input | 1 | Asynchronous index pulse from the medium |
| mclk_raw | input | 1 | Asynchronous medium clock |
| seq_state | output | 4 | One-hot state {finished, active, armed, idle} |
| xfer_active | output | 1 | Active transfer window enable |
| flag_out | output | 1 | Sector transfer finished |
| dir_write | output | 1 | 1 = write direction, 0 = read |
| trk_addr | output | TRK_W | Current track address |
| sec_addr | output | SEC_W | Current sector address |
| addr_adv | output | 1 | One-cycle pulse when the address steps |
| take_word | output | 1 | One-cycle word request issued by continue |
| skip | output | 1 | Registered answer to a sense command |

## Verification
Two functions can collide on the error flags: the clear done by a continue command and an error report from the data path can land in the same cycle. The bench provokes this by driving `cmd_continue` and `data_err_set` on the same clock edge while the finished state holds. It then checks that the state moves to armed and that `take_word` pulses, and that a following error sense returns skip 0 because the report survived the clear. A later start command is expected to clear the flag so that the same sense returns 1.

// File: rtl/rotstore_pkg.sv
package rotstore_pkg;

    typedef enum logic [3:0] {
        SEQ_IDLE = 4'b0001,
        SEQ_TRA  = 4'b0010,
        SEQ_ACT  = 4'b0100,
        SEQ_FLAG = 4'b1000
    } seq_state_e;

endpackage

// File: rtl/rs_sync_edge.sv
module rs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rs_delay_timer.sv
module rs_delay_timer #(
    parameter int CYCLES = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          run_q, run_d;
    logic          exp_q, exp_d;

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        exp_d = 1'b0;
        if (cancel) begin
            run_d = 1'b0;
            cnt_d = '0;
        end else if (start) begin
            run_d = 1'b1;
            cnt_d = '0;
        end else if (run_q) begin
            if (cnt_q == CW'(CYCLES - 1)) begin
                run_d = 1'b0;
                exp_d = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            exp_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
            exp_q <= exp_d;
        end
    end

    assign expired = exp_q;
endmodule

// File: rtl/rs_gap_watch.sv
module rs_gap_watch #(
    parameter int CYCLES = 680
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic clk_live
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          live_q, live_d;

    always_comb begin
        cnt_d  = cnt_q;
        live_d = live_q;
        if (trig) begin
            cnt_d  = '0;
            live_d = 1'b1;
        end else if (live_q) begin
            if (cnt_q == CW'(CYCLES - 1)) begin
                live_d = 1'b0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            live_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            live_q <= live_d;
        end
    end

    assign clk_live = live_q;
endmodule

// File: rtl/rotstore_seq.sv
module rotstore_seq
    import rotstore_pkg::*;
#(
    parameter int CLK_MHZ   = 200,
    parameter int SETTLE_US = 200,
    parameter int GAP_NS    = 3400,
    parameter int TRK_W     = 6,
    parameter int SEC_W     = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_start_write,
    input  logic                     cmd_start_read,
    input  logic                     cmd_load_addr,
    input  logic [TRK_W+SEC_W-1:0]   addr_in,
    input  logic                     cmd_continue,
    input  logic                     cmd_sense_flag,
    input  logic                     cmd_sense_err,
    input  logic                     par_err_set,
    input  logic                     data_err_set,
    input  logic                     index_raw,
    input  logic                     mclk_raw,
    output logic [3:0]               seq_state,
    output logic                     xfer_active,
    output logic                     flag_out,
    output logic                     dir_write,
    output logic [TRK_W-1:0]         trk_addr,
    output logic [SEC_W-1:0]         sec_addr,
    output logic                     addr_adv,
    output logic                     take_word,
    output logic                     skip
);
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int GAP_CYC    = (CLK_MHZ * GAP_NS) / 1000;
    localparam int ADDR_W     = TRK_W + SEC_W;
    localparam int N_SYNC     = 2;

    typedef struct packed {
        seq_state_e          st;
        logic                dir_wr;
        logic [ADDR_W-1:0]   addr;
        logic                perr;
        logic                derr;
        logic                adv;
        logic                take;
        logic                skip;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [N_SYNC-1:0] raw_vec;
    logic [N_SYNC-1:0] rise_vec;
    logic              index_rise;
    logic              mclk_rise;
    logic              start_any;
    logic              settle_go;
    logic              settle_done;
    logic              clk_live;

    assign raw_vec    = {mclk_raw, index_raw};
    assign index_rise = rise_vec[0];
    assign mclk_rise  = rise_vec[1];

    for (genvar gi = 0; gi < N_SYNC; gi++) begin : g_sync
        rs_sync_edge #(.STAGES(2)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_vec[gi]),
            .rise  (rise_vec[gi])
        );
    end

    assign start_any = cmd_start_write | cmd_start_read;
    assign settle_go = cmd_load_addr & ~start_any & (ctl_q.st == SEQ_IDLE);

    rs_delay_timer #(.CYCLES(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (settle_go),
        .cancel  (start_any),
        .expired (settle_done)
    );

    rs_gap_watch #(.CYCLES(GAP_CYC)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (index_rise | mclk_rise),
        .clk_live (clk_live)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.adv  = 1'b0;
        ctl_d.take = 1'b0;
        ctl_d.skip = (cmd_sense_flag & (ctl_q.st == SEQ_FLAG))
                   | (cmd_sense_err & ~ctl_q.perr & ~ctl_q.derr);

        if (start_any) begin
            ctl_d.st     = SEQ_IDLE;
            ctl_d.dir_wr = cmd_start_write;
            ctl_d.perr   = 1'b0;
            ctl_d.derr   = 1'b0;
        end else begin
            unique case (ctl_q.st)
                SEQ_IDLE: begin
                    if (cmd_load_addr) begin
                        ctl_d.addr = addr_in;
                    end
                    if (settle_done) begin
                        ctl_d.st = SEQ_TRA;
                    end
                end
                SEQ_TRA: begin
                    if (index_rise) begin
                        ctl_d.st = SEQ_ACT;
                    end
                end
                SEQ_ACT: begin
                    if (!clk_live) begin
                        ctl_d.st   = SEQ_FLAG;
                        ctl_d.addr = ctl_q.addr + 1'b1;
                        ctl_d.adv  = 1'b1;
                    end
                end
                SEQ_FLAG: begin
                    if (cmd_continue) begin
                        ctl_d.st   = SEQ_TRA;
                        ctl_d.take = 1'b1;
                        ctl_d.perr = 1'b0;
                        ctl_d.derr = 1'b0;
                    end
                end
                default: ctl_d.st = SEQ_IDLE;
            endcase
        end

        if (par_err_set) begin
            ctl_d.perr = 1'b1;
        end
        if (data_err_set) begin
            ctl_d.derr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st     <= SEQ_IDLE;
            ctl_q.dir_wr <= 1'b0;
            ctl_q.addr   <= '0;
            ctl_q.perr   <= 1'b0;
            ctl_q.derr   <= 1'b0;
            ctl_q.adv    <= 1'b0;
            ctl_q.take   <= 1'b0;
            ctl_q.skip   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign seq_state   = ctl_q.st;
    assign xfer_active = (ctl_q.st == SEQ_ACT);
    assign flag_out    = (ctl_q.st == SEQ_FLAG);
    assign dir_write   = ctl_q.dir_wr;
    assign trk_addr    = ctl_q.addr[ADDR_W-1:SEC_W];
    assign sec_addr    = ctl_q.addr[SEC_W-1:0];
    assign addr_adv    = ctl_q.adv;
    assign take_word   = ctl_q.take;
    assign skip        = ctl_q.skip;
endmodule

// File: rtl/rs_seq_checker.sv
module rs_seq_checker #(
    parameter int TRK_W = 6,
    parameter int SEC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start_write,
    input logic             cmd_start_read,
    input logic [3:0]       seq_state,
    input logic             dir_write,
    input logic [TRK_W-1:0] trk_addr,
    input logic [SEC_W-1:0] sec_addr,
    input logic             addr_adv,
    input logic             take_word
);
    localparam logic [3:0] S_IDLE = 4'b0001;
    localparam logic [3:0] S_TRA  = 4'b0010;
    localparam logic [3:0] S_ACT  = 4'b0100;
    localparam logic [3:0] S_FLAG = 4'b1000;

    // R10: exactly one state bit
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seq_state) == 1);

    // R10: active only entered from armed
    a_r10_act_from_tra: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == S_ACT && $past(seq_state) != S_ACT) |-> $past(seq_state) == S_TRA);

    // R10: finished only entered from active
    a_r10_flag_from_act: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == S_FLAG && $past(seq_state) != S_FLAG) |-> $past(seq_state) == S_ACT);

    // R10: armed only entered from idle or finished
    a_r10_tra_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == S_TRA && $past(seq_state) != S_TRA)
            |-> ($past(seq_state) == S_IDLE || $past(seq_state) == S_FLAG));

    // R2: start write forces idle with write direction
    a_r2_start_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_write |=> (seq_state == S_IDLE && dir_write));

    // R2: start read alone forces idle with read direction
    a_r2_start_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start_read && !cmd_start_write) |=> (seq_state == S_IDLE && !dir_write));

    // R6: advance pulse only on the active-to-finished step
    a_r6_adv_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        addr_adv |-> (seq_state == S_FLAG && $past(seq_state) == S_ACT));

    // R6: address steps by one with carry into the track
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        addr_adv |-> ({trk_addr, sec_addr} == $past({trk_addr, sec_addr}) + 1'b1));

    // R7: take-word pulse only when continue re-arms from finished
    a_r7_take_word: assert property (@(posedge clk) disable iff (!rst_n)
        take_word |-> (seq_state == S_TRA && $past(seq_state) == S_FLAG));
endmodule

bind rotstore_seq rs_seq_checker #(.TRK_W(TRK_W), .SEC_W(SEC_W)) u_seq_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_start_write (cmd_start_write),
    .cmd_start_read  (cmd_start_read),
    .seq_state       (seq_state),
    .dir_write       (dir_write),
    .trk_addr        (trk_addr),
    .sec_addr        (sec_addr),
    .addr_adv        (addr_adv),
    .take_word       (take_word)
);

// File: tb/rotstore_seq_tb_top.sv
`timescale 1ns/1ps
module rotstore_seq_tb_top;
    localparam int TRK_W  = 6;
    localparam int SEC_W  = 3;
    localparam int SETTLE = 200 * 1;
    localparam int GAP    = (200 * 100) / 1000;

    localparam logic [3:0] S_IDLE = 4'b0001;
    localparam logic [3:0] S_TRA  = 4'b0010;
    localparam logic [3:0] S_ACT  = 4'b0100;
    localparam logic [3:0] S_FLAG = 4'b1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start_write = 1'b0, cmd_start_read = 1'b0, cmd_load_addr = 1'b0;
    logic [TRK_W+SEC_W-1:0] addr_in = '0;
    logic cmd_continue = 1'b0, cmd_sense_flag = 1'b0, cmd_sense_err = 1'b0;
    logic par_err_set = 1'b0, data_err_set = 1'b0;
    logic index_raw = 1'b0, mclk_raw = 1'b0;
    logic [3:0] seq_state;
    logic xfer_active, flag_out, dir_write, addr_adv, take_word, skip;
    logic [TRK_W-1:0] trk_addr;
    logic [SEC_W-1:0] sec_addr;

    int checks = 0;
    int errors = 0;
    int adv_cnt = 0;
    int take_cnt = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rotstore_seq #(
        .CLK_MHZ(200), .SETTLE_US(1), .GAP_NS(100), .TRK_W(TRK_W), .SEC_W(SEC_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_start_write(cmd_start_write), .cmd_start_read(cmd_start_read),
        .cmd_load_addr(cmd_load_addr), .addr_in(addr_in),
        .cmd_continue(cmd_continue), .cmd_sense_flag(cmd_sense_flag),
        .cmd_sense_err(cmd_sense_err), .par_err_set(par_err_set),
        .data_err_set(data_err_set), .index_raw(index_raw), .mclk_raw(mclk_raw),
        .seq_state(seq_state), .xfer_active(xfer_active), .flag_out(flag_out),
        .dir_write(dir_write), .trk_addr(trk_addr), .sec_addr(sec_addr),
        .addr_adv(addr_adv), .take_word(take_word), .skip(skip)
    );

    always @(negedge clk) begin
        if (addr_adv)  adv_cnt++;
        if (take_word) take_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic pulse_cmd(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
    endtask

    task automatic pulse_raw(ref logic sig);
        @(negedge clk) sig = 1'b1;
        repeat (2) @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic sense_flag_is(input string req, input int exp);
        pulse_cmd(cmd_sense_flag);
        chk_eq(req, skip, exp);
    endtask

    task automatic sense_err_is(input string req, input int exp);
        pulse_cmd(cmd_sense_err);
        chk_eq(req, skip, exp);
    endtask

    task automatic load_and_settle(input logic [TRK_W-1:0] t, input logic [SEC_W-1:0] s);
        @(negedge clk) begin addr_in = {t, s}; cmd_load_addr = 1'b1; end
        @(negedge clk) cmd_load_addr = 1'b0;
        repeat (SETTLE) @(negedge clk);
        chk_eq("R3 still idle one cycle before arming", seq_state, S_IDLE);
        @(negedge clk);
        chk_eq("R3 armed after settle", seq_state, S_TRA);
    endtask

    task automatic run_sector(input int n_clks);
        pulse_raw(index_raw);
        repeat (2) @(negedge clk);
        chk_eq("R4 index enters active", seq_state, S_ACT);
        for (int i = 0; i < n_clks; i++) begin
            pulse_raw(mclk_raw);
            repeat (5) @(negedge clk);
        end
        chk_eq("R5 active held while clocks arrive", seq_state, S_ACT);
        repeat (GAP / 2) @(negedge clk);
        chk_eq("R5 active held inside gap timeout", seq_state, S_ACT);
        repeat (GAP + 6) @(negedge clk);
        chk_eq("R5 finished after clock loss", seq_state, S_FLAG);
    endtask

    task automatic t_reset();
        chk_eq("R1 reset state idle", seq_state, S_IDLE);
        chk_eq("R1 reset active low", xfer_active, 0);
        chk_eq("R1 reset flag low", flag_out, 0);
        chk_eq("R1 reset direction read", dir_write, 0);
        chk_eq("R1 reset address zero", {trk_addr, sec_addr}, 0);
        sense_err_is("R1 reset errors clear", 1);
    endtask

    task automatic t_write_sector();
        int adv0;
        pulse_cmd(cmd_start_write);
        chk_eq("R2 start write idle", seq_state, S_IDLE);
        chk_eq("R2 start write direction", dir_write, 1);
        load_and_settle(6'd3, 3'd7);
        chk_eq("R3 track loaded", trk_addr, 3);
        chk_eq("R3 sector loaded", sec_addr, 7);
        adv0 = adv_cnt;
        run_sector(12);
        chk_eq("R6 one advance pulse", adv_cnt - adv0, 1);
        chk_eq("R6 sector wraps", sec_addr, 0);
        chk_eq("R6 track carries", trk_addr, 4);
        sense_flag_is("R8 sense flag in finished", 1);
    endtask

    task automatic t_ignored();
        int tk0;
        pulse_cmd(cmd_start_read);
        chk_eq("R2 start read from finished", seq_state, S_IDLE);
        chk_eq("R2 start read direction", dir_write, 0);
        pulse_raw(index_raw);
        repeat (3) @(negedge clk);
        chk_eq("R4 index ignored in idle", seq_state, S_IDLE);
        tk0 = take_cnt;
        pulse_cmd(cmd_continue);
        @(negedge clk);
        chk_eq("R7 continue ignored in idle state", seq_state, S_IDLE);
        chk_eq("R7 continue ignored no take", take_cnt - tk0, 0);
        sense_flag_is("R8 sense flag in idle", 0);
    endtask

    task automatic t_load_outside_idle();
        load_and_settle(6'd5, 3'd2);
        @(negedge clk) begin addr_in = {6'd9, 3'd6}; cmd_load_addr = 1'b1; end
        @(negedge clk) cmd_load_addr = 1'b0;
        chk_eq("R3 load ignored in armed track", trk_addr, 5);
        chk_eq("R3 load ignored in armed sector", sec_addr, 2);
        chk_eq("R3 load keeps armed", seq_state, S_TRA);
    endtask

    task automatic t_continue();
        int tk0;
        run_sector(4);
        chk_eq("R6 plain sector step", sec_addr, 3);
        pulse_cmd(par_err_set);
        sense_err_is("R9 parity error blocks skip", 0);
        tk0 = take_cnt;
        pulse_cmd(cmd_continue);
        chk_eq("R7 continue re-arms", seq_state, S_TRA);
        @(negedge clk);
        chk_eq("R7 take word pulse", take_cnt - tk0, 1);
        sense_err_is("R7 continue clears errors", 1);
    endtask

    task automatic t_concurrent();
        int tk0;
        run_sector(3);
        tk0 = take_cnt;
        @(negedge clk) begin cmd_continue = 1'b1; data_err_set = 1'b1; end
        @(negedge clk) begin cmd_continue = 1'b0; data_err_set = 1'b0; end
        chk_eq("R9 continue with error still re-arms", seq_state, S_TRA);
        @(negedge clk);
        chk_eq("R9 continue with error takes word", take_cnt - tk0, 1);
        sense_err_is("R9 error set wins over clear", 0);
        pulse_cmd(cmd_start_write);
        sense_err_is("R2 start clears errors", 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_sector();
        t_ignored();
        t_load_outside_idle();
        t_continue();
        t_concurrent();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule